// File: doc/BRIEF.md
# Local Interrupt Pin Entry

This block is a single programmable entry of a processor's local interrupt table, together with the logic that turns one external interrupt line into requests for the core. Software programs a 32-bit entry word that selects the vector, the delivery mode, the line polarity, the trigger style and a mask. The block synchronizes the line, applies the polarity, detects edges or levels, and presents a request that carries the vector and mode to the core.

Hardware owns part of the entry. The delivery-status bit shows that a request is outstanding until the core accepts it. The remote in-service flag tracks fixed-mode level interrupts from acceptance until the end-of-interrupt pulse. A source built as a performance-counter entry masks itself each time it fires. The delivery mode overrides the trigger bit, and a parameter selects whether the entry serves the external line or an internal timer, error or counter source. Internal sources always detect edges.

Top module: `lvt_pin_entry`

## Requirements
- R1: After reset, `rd_data` reads 0x0001_0000 (only the mask bit, bit 16, is set) and `req_valid` is 0.
- R2: The entry word layout is: vector [7:0], delivery mode [10:8], delivery status [12], polarity [13], remote in-service [14], trigger [15], mask [16], timer mode [18:17]. Writes update only the vector, mode, polarity, trigger, mask and timer-mode fields. Bits 12 and 14 reflect hardware state only, and every other bit reads 0.
- R3: Polarity 0 treats a high line as active. Polarity 1 treats a low line as active.
- R4: In Fixed mode (000), trigger 0 gives edge detection: one request per inactive-to-active transition. Trigger 1 gives level detection: a request is raised again while the line stays active and remote in-service is clear. A line change produces `req_valid` on the third rising clock edge after it.
- R5: In SMI (010), NMI (100) and INIT (101) modes, detection is edge-triggered whatever the trigger bit holds. In ExtINT (111) mode, detection is level-triggered whatever the trigger bit holds.
- R6: `req_valid` and delivery status (bit 12) rise together when a request is issued. They stay set until a cycle with `accept` high, and they clear on the following edge.
- R7: In Fixed level mode, remote in-service (bit 14) sets when a pending request is accepted and clears on `eoi`. No level request is raised while it is set. In every other mode it reads 0.
- R8: While the mask bit is set, no new request is issued, and edges that occur while masked are discarded. A request that is already pending stays pending until it is accepted.
- R9: With the performance-counter source kind, the mask bit sets itself on the same edge that a request is issued.
- R10: With a timer, error or performance-counter source kind, detection is always edge-triggered, whatever the mode and trigger bits hold.
- R11: While a request is pending, `req_vector` and `req_mode` carry the vector and delivery-mode fields of the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the entry word |
| wr_data | input | WORD_W | Entry word to write |
| rd_data | output | WORD_W | Current entry word, including the hardware-owned bits |
| pin_in | input | 1 | Asynchronous interrupt line or internal source line |
| req_valid | output | 1 | Request outstanding toward the core |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_level | output | 1 | Effective trigger style in use (1 = level) |
| accept | input | 1 | Core accepts the outstanding request |
| eoi | input | 1 | End-of-interrupt pulse from the core |

## Verification
A wrong pending flag shows up as a missing or duplicated request. This is visible at `req_valid` and bit 12 on the edge after the stimulus: three edges after a line change, or one edge after `accept`. A remote in-service flag that sets or clears wrongly shows up as a level request that repeats before `eoi`, or as one that never returns after it. A wrong effective trigger choice shows up as a single request where a repeat was due, or a repeat where one request was due. A broken mask shows up as a request that a discarded edge should not have caused, or as an auto-masked counter entry that keeps firing.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

   localparam int VEC_BITS  = 8;
   localparam int VEC_LSB   = 0;
   localparam int DM_LSB    = 8;
   localparam int STAT_BIT  = 12;
   localparam int POL_BIT   = 13;
   localparam int RIRR_BIT  = 14;
   localparam int TRIG_BIT  = 15;
   localparam int MASK_BIT  = 16;
   localparam int TMR_LSB   = 17;
   localparam int MIN_WORD  = TMR_LSB + 2;

   localparam logic [2:0] DM_FIXED  = 3'b000;
   localparam logic [2:0] DM_SMI    = 3'b010;
   localparam logic [2:0] DM_NMI    = 3'b100;
   localparam logic [2:0] DM_INIT   = 3'b101;
   localparam logic [2:0] DM_EXTINT = 3'b111;

   typedef enum logic [1:0] {
      SRC_PIN   = 2'd0,
      SRC_TIMER = 2'd1,
      SRC_ERROR = 2'd2,
      SRC_PERF  = 2'd3
   } src_kind_e;

   typedef struct packed {
      logic [VEC_BITS-1:0] vector;
      logic [2:0]          dmode;
      logic                pol;
      logic                trig;
      logic                mask;
      logic [1:0]          tmode;
   } entry_cfg_t;

endpackage

// File: rtl/lvt_pin_sync.sv
module lvt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lvt_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lvt_trigger_detect.sv
module lvt_trigger_detect
   import lvt_pkg::*;
#(
   parameter src_kind_e SRC_KIND = SRC_PIN
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_sync,
   input  logic       polarity,
   input  logic [2:0] dmode,
   input  logic       trig_bit,
   output logic       active,
   output logic       rise,
   output logic       level_sel
);

   logic active_prev_q;

   assign active = line_sync ^ polarity;
   assign rise   = active & ~active_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_prev_q <= 1'b0;
      else        active_prev_q <= active;
   end

   if (SRC_KIND == SRC_PIN) begin : g_pin_trigger
      always_comb begin
         unique case (dmode)
            DM_FIXED:  level_sel = trig_bit;
            DM_EXTINT: level_sel = 1'b1;
            default:   level_sel = 1'b0;
         endcase
      end
   end else begin : g_internal_trigger
      assign level_sel = 1'b0;
   end

endmodule

// File: rtl/lvt_entry_regs.sv
module lvt_entry_regs
   import lvt_pkg::*;
#(
   parameter src_kind_e SRC_KIND = SRC_PIN,
   parameter int        WORD_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fire,
   output entry_cfg_t        cfg
);

   localparam bit AUTO_MASK = (SRC_KIND == SRC_PERF);

   entry_cfg_t cfg_q;
   logic       mask_d;

   if (AUTO_MASK) begin : g_auto_mask
      assign mask_d = fire ? 1'b1 : (wr_en ? wr_data[MASK_BIT] : cfg_q.mask);
   end else begin : g_soft_mask
      assign mask_d = wr_en ? wr_data[MASK_BIT] : cfg_q.mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.vector <= '0;
         cfg_q.dmode  <= DM_FIXED;
         cfg_q.pol    <= 1'b0;
         cfg_q.trig   <= 1'b0;
         cfg_q.tmode  <= '0;
         cfg_q.mask   <= 1'b1;
      end else begin
         if (wr_en) begin
            cfg_q.vector <= wr_data[VEC_LSB +: VEC_BITS];
            cfg_q.dmode  <= wr_data[DM_LSB +: 3];
            cfg_q.pol    <= wr_data[POL_BIT];
            cfg_q.trig   <= wr_data[TRIG_BIT];
            cfg_q.tmode  <= wr_data[TMR_LSB +: 2];
         end
         cfg_q.mask <= mask_d;
      end
   end

   assign cfg = cfg_q;

   if (AUTO_MASK) begin : g_auto_mask_chk
      // R9
      auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fire |=> cfg_q.mask);
   end

endmodule

// File: rtl/lvt_request_fsm.sv
module lvt_request_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic masked,
   input  logic level_sel,
   input  logic fixed_mode,
   input  logic active,
   input  logic rise,
   input  logic accept,
   input  logic eoi,
   output logic fire,
   output logic pending,
   output logic rirr
);

   logic pending_q;
   logic rirr_q;
   logic fixed_level;

   assign fixed_level = fixed_mode & level_sel;

   always_comb begin
      fire = 1'b0;
      if (!masked && !pending_q) begin
         if (level_sel) fire = active & ~rirr_q;
         else           fire = rise;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pending_q <= 1'b0;
      else if (fire)               pending_q <= 1'b1;
      else if (accept)             pending_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rirr_q <= 1'b0;
      else if (!fixed_level || eoi)     rirr_q <= 1'b0;
      else if (accept && pending_q)     rirr_q <= 1'b1;
   end

   assign pending = pending_q;
   assign rirr    = rirr_q;

   // R6
   pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !accept) |=> pending_q);

   // R6
   accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && accept) |=> !pending_q);

   // R7
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> !rirr_q);

   // R8
   masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masked && !pending_q) |=> !pending_q);

endmodule

// File: rtl/lvt_pin_entry.sv
module lvt_pin_entry
   import lvt_pkg::*;
#(
   parameter int        WORD_W      = 32,
   parameter int        SYNC_STAGES = 2,
   parameter src_kind_e SRC_KIND    = SRC_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   input  logic              pin_in,
   output logic              req_valid,
   output logic [7:0]        req_vector,
   output logic [2:0]        req_mode,
   output logic              req_level,
   input  logic              accept,
   input  logic              eoi
);

   if (WORD_W < MIN_WORD) begin : g_bad_word
      $error("lvt_pin_entry: WORD_W too narrow for the entry layout");
   end

   entry_cfg_t cfg;
   logic       line_sync;
   logic       active;
   logic       rise;
   logic       level_sel;
   logic       fire;
   logic       pending;
   logic       rirr;

   lvt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (line_sync)
   );

   lvt_trigger_detect #(.SRC_KIND(SRC_KIND)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_sync (line_sync),
      .polarity  (cfg.pol),
      .dmode     (cfg.dmode),
      .trig_bit  (cfg.trig),
      .active    (active),
      .rise      (rise),
      .level_sel (level_sel)
   );

   lvt_entry_regs #(.SRC_KIND(SRC_KIND), .WORD_W(WORD_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .fire    (fire),
      .cfg     (cfg)
   );

   lvt_request_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .masked     (cfg.mask),
      .level_sel  (level_sel),
      .fixed_mode (cfg.dmode == DM_FIXED),
      .active     (active),
      .rise       (rise),
      .accept     (accept),
      .eoi        (eoi),
      .fire       (fire),
      .pending    (pending),
      .rirr       (rirr)
   );

   always_comb begin
      rd_data                        = '0;
      rd_data[VEC_LSB +: VEC_BITS]   = cfg.vector;
      rd_data[DM_LSB +: 3]           = cfg.dmode;
      rd_data[STAT_BIT]              = pending;
      rd_data[POL_BIT]               = cfg.pol;
      rd_data[RIRR_BIT]              = rirr;
      rd_data[TRIG_BIT]              = cfg.trig;
      rd_data[MASK_BIT]              = cfg.mask;
      rd_data[TMR_LSB +: 2]          = cfg.tmode;
   end

   assign req_valid  = pending;
   assign req_vector = cfg.vector;
   assign req_mode   = cfg.dmode;
   assign req_level  = level_sel;

   // R7
   rirr_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rirr) |-> $past(pending));

endmodule

// File: tb/lvt_pin_entry_bench.sv
module lvt_pin_entry_bench;
   import lvt_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pin_in = 1'b0;
   logic        req_valid;
   logic [7:0]  req_vector;
   logic [2:0]  req_mode;
   logic        req_level;
   logic        accept = 1'b0;
   logic        eoi = 1'b0;

   logic        p_wr_en = 1'b0;
   logic [31:0] p_wr_data = '0;
   logic [31:0] p_rd_data;
   logic        p_pin = 1'b0;
   logic        p_req_valid;
   logic [7:0]  p_req_vector;
   logic [2:0]  p_req_mode;
   logic        p_req_level;
   logic        p_accept = 1'b0;
   logic        p_eoi = 1'b0;

   int tests_run = 0;
   int tests_failed = 0;
   bit done = 1'b0;

   typedef struct packed { logic [7:0] v; logic [2:0] m; } exp_t;
   exp_t exp_q[$];
   logic prev_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lvt_pin_entry u_lvt_pin_entry (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pin_in(pin_in), .req_valid(req_valid),
      .req_vector(req_vector), .req_mode(req_mode), .req_level(req_level),
      .accept(accept), .eoi(eoi)
   );

   lvt_pin_entry #(.SRC_KIND(SRC_PERF)) u_perf (
      .clk(clk), .rst_n(rst_n), .wr_en(p_wr_en), .wr_data(p_wr_data),
      .rd_data(p_rd_data), .pin_in(p_pin), .req_valid(p_req_valid),
      .req_vector(p_req_vector), .req_mode(p_req_mode), .req_level(p_req_level),
      .accept(p_accept), .eoi(p_eoi)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      tests_run++;
      if (!ok) begin
         tests_failed++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_accept();
      accept = 1'b1;
      @(negedge clk);
      accept = 1'b0;
   endtask

   task automatic pulse_eoi();
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
   endtask

   task automatic expect_req(input logic [7:0] v, input logic [2:0] m);
      exp_t e;
      e.v = v; e.m = m;
      exp_q.push_back(e);
   endtask

   // Scoreboard monitor: each new request must match the next expected item (R11)
   always @(negedge clk) begin
      if (rst_n) begin
         if (req_valid && !prev_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected request", {21'd0, req_mode, req_vector}, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(req_vector == e.v && req_mode == e.m, "R11 request payload",
                     {21'd0, req_mode, req_vector}, {21'd0, e.m, e.v});
            end
         end
         prev_valid = req_valid;
      end
   end

   task automatic forced_edge(input logic [2:0] m, input logic [7:0] v);
      wr({16'h0000, 1'b1, 4'b0000, m, v});
      expect_req(v, m);
      pin_in = 1'b1;
      step(3);
      check(req_valid === 1'b1, "R5 forced edge request", {31'd0, req_valid}, 32'd1);
      check(req_level === 1'b0, "R5 forced edge style", {31'd0, req_level}, 32'd0);
      pulse_accept();
      step(5);
      check(req_valid === 1'b0, "R5 no repeat in edge mode", {31'd0, req_valid}, 32'd0);
      pin_in = 1'b0;
      step(3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      check(rd_data === 32'h0001_0000, "R1 reset word", rd_data, 32'h0001_0000);
      check(req_valid === 1'b0, "R1 reset request", {31'd0, req_valid}, 32'd0);

      // R2 layout, read-only and unused bits
      wr(32'hFFFF_FFFF);
      check(rd_data === 32'h0007_A7FF, "R2 all-ones readback", rd_data, 32'h0007_A7FF);
      wr(32'h0001_0000);
      check(rd_data === 32'h0001_0000, "R2 restore", rd_data, 32'h0001_0000);

      // R4 fixed edge
      wr(32'h0000_0031);
      expect_req(8'h31, DM_FIXED);
      pin_in = 1'b1;
      step(2);
      check(req_valid === 1'b0, "R4 latency before third edge", {31'd0, req_valid}, 32'd0);
      step(1);
      check(req_valid === 1'b1, "R4 edge request", {31'd0, req_valid}, 32'd1);
      check(rd_data[12] === 1'b1, "R6 status set", rd_data, 32'h0000_1031);
      pulse_accept();
      check(req_valid === 1'b0, "R6 cleared by accept", {31'd0, req_valid}, 32'd0);
      check(rd_data[12] === 1'b0, "R6 status clear", rd_data, 32'h0000_0031);
      step(6);
      check(req_valid === 1'b0, "R4 edge no repeat", {31'd0, req_valid}, 32'd0);
      pin_in = 1'b0;
      step(3);

      // R4/R7 fixed level with remote in-service
      wr(32'h0000_8042);
      expect_req(8'h42, DM_FIXED);
      pin_in = 1'b1;
      step(3);
      check(req_valid === 1'b1, "R4 level request", {31'd0, req_valid}, 32'd1);
      pulse_accept();
      check(rd_data[14] === 1'b1, "R7 rirr set on accept", rd_data, 32'h0000_C042);
      step(5);
      check(req_valid === 1'b0, "R7 level blocked by rirr", {31'd0, req_valid}, 32'd0);
      expect_req(8'h42, DM_FIXED);
      pulse_eoi();
      check(rd_data[14] === 1'b0, "R7 rirr cleared by eoi", rd_data, 32'h0000_8042);
      step(1);
      check(req_valid === 1'b1, "R4 level re-request after eoi", {31'd0, req_valid}, 32'd1);
      pin_in = 1'b0;
      step(3);
      pulse_accept();
      pulse_eoi();
      step(3);
      check(req_valid === 1'b0 && rd_data[14] === 1'b0, "R7 idle after eoi, line inactive",
            rd_data, 32'h0000_8042);

      // R3 active-low polarity
      wr(32'h0001_2055);
      step(4);
      wr(32'h0000_2055);
      step(4);
      check(req_valid === 1'b0, "R3 steady active low no edge", {31'd0, req_valid}, 32'd0);
      expect_req(8'h55, DM_FIXED);
      pin_in = 1'b1;
      step(4);
      check(req_valid === 1'b0, "R3 high is inactive", {31'd0, req_valid}, 32'd0);
      pin_in = 1'b0;
      step(3);
      check(req_valid === 1'b1, "R3 falling line fires", {31'd0, req_valid}, 32'd1);
      pulse_accept();

      // R5 forced trigger styles
      wr(32'h0001_8466);
      step(2);
      forced_edge(DM_NMI, 8'h66);
      forced_edge(DM_SMI, 8'h67);
      forced_edge(DM_INIT, 8'h68);

      wr(32'h0000_0777);
      check(req_level === 1'b1, "R5 extint forced level", {31'd0, req_level}, 32'd1);
      expect_req(8'h77, DM_EXTINT);
      pin_in = 1'b1;
      step(3);
      check(req_valid === 1'b1, "R5 extint request", {31'd0, req_valid}, 32'd1);
      expect_req(8'h77, DM_EXTINT);
      pulse_accept();
      step(1);
      check(req_valid === 1'b1, "R5 extint level repeat", {31'd0, req_valid}, 32'd1);
      check(rd_data[14] === 1'b0, "R7 rirr reads 0 outside fixed", rd_data, 32'h0000_1777);
      pin_in = 1'b0;
      step(3);
      pulse_accept();
      step(3);
      check(req_valid === 1'b0, "R5 extint idle", {31'd0, req_valid}, 32'd0);

      // R8 masking
      wr(32'h0001_0012);
      pin_in = 1'b1;
      step(4);
      check(req_valid === 1'b0, "R8 masked no request", {31'd0, req_valid}, 32'd0);
      wr(32'h0000_0012);
      step(4);
      check(req_valid === 1'b0, "R8 masked edge discarded", {31'd0, req_valid}, 32'd0);
      pin_in = 1'b0;
      step(3);
      expect_req(8'h12, DM_FIXED);
      pin_in = 1'b1;
      step(3);
      check(req_valid === 1'b1, "R8 unmasked edge fires", {31'd0, req_valid}, 32'd1);
      wr(32'h0001_0012);
      step(1);
      check(req_valid === 1'b1 && rd_data[12] === 1'b1, "R8 pending survives mask",
            rd_data, 32'h0001_1012);
      pulse_accept();
      check(req_valid === 1'b0, "R8 pending completes", {31'd0, req_valid}, 32'd0);
      pin_in = 1'b0;
      step(3);

      // R9/R10 performance-counter source
      check(p_rd_data === 32'h0001_0000, "R1 perf reset word", p_rd_data, 32'h0001_0000);
      p_wr_en = 1'b1; p_wr_data = 32'h0000_8020;
      @(negedge clk);
      p_wr_en = 1'b0;
      check(p_req_level === 1'b0, "R10 internal source edge", {31'd0, p_req_level}, 32'd0);
      p_pin = 1'b1;
      step(3);
      check(p_req_valid === 1'b1 && p_req_vector === 8'h20, "R9 perf request",
            {23'd0, p_req_valid, p_req_vector}, 32'h0000_0120);
      check(p_rd_data[16] === 1'b1, "R9 auto mask on issue", p_rd_data, 32'h0001_9020);
      p_accept = 1'b1;
      @(negedge clk);
      p_accept = 1'b0;
      step(5);
      check(p_req_valid === 1'b0, "R9 masked after delivery", {31'd0, p_req_valid}, 32'd0);
      p_wr_en = 1'b1; p_wr_data = 32'h0000_8020;
      @(negedge clk);
      p_wr_en = 1'b0;
      step(5);
      check(p_req_valid === 1'b0 && p_rd_data[14] === 1'b0, "R10 no level repeat",
            p_rd_data, 32'h0000_8020);

      check(exp_q.size() == 0, "R11 all expected requests seen", exp_q.size(), 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

endmodule